// File: doc/BRIEF.md
# Oscillator Clock Divider with Suspend

This block turns a free-running high-frequency oscillator clock into a system clock. The system clock is modelled as a train of clock-enable pulses in the oscillator domain. A fixed divide-by-4 prescaler runs first. A post-divider follows it and divides by 1, 2, 4 or 8, so the total division is 4, 8, 16 or 32. Software controls the block through a small register interface with two registers. The control register holds the divide select, a suspend bit and an oscillator-enable bit. The trim register holds a 7-bit calibration code, which is passed on to the analog oscillator.

A write that sets the suspend bit stops the enable pulses and freezes both dividers. An external wake pin is synchronized into the oscillator domain. Either a rising or a falling edge on that pin clears the suspend bit, and delivery then resumes from where the dividers stopped. A new divide ratio takes effect only at the end of the divided period in progress, so no shortened pulse interval appears. The trim code can be changed only while the oscillator-enable bit is 0.

Top module: `osc_clk_div`

## Requirements
- R1: Reset state. `clk_en_o` is low during reset. The control register (address 0) reads 0x0B: bits [1:0] = 3 for divide by 8, bit 2 = 0 (suspend clear), bit 3 = 1 (oscillator enabled). The trim register (address 1) reads the `TRIM_RST` parameter value.
- R2: `clk_en_o` is high for exactly one cycle in each divided period.
- R3: The interval between pulses is 4 × N cycles. The divide field selects N: value 0, 1, 2 or 3 gives N = 1, 2, 4 or 8, which is 4, 8, 16 or 32 cycles. After reset the interval is 32 cycles.
- R4: A write to the divide field does not shorten or lengthen the period in progress. That period completes at the old ratio, and later periods use the new ratio.
- R5: Writing 1 to control bit 2 suspends the block. `clk_en_o` stays low from the cycle after the write. Both dividers hold their count while suspended.
- R6: While suspended, a rising edge on `wake_pin_i` clears the suspend bit. It passes through a two-flop synchronizer and is detected by comparing the synchronized value with its previous sample. The suspend bit clears on the third clock edge after the pin changes.
- R7: While suspended, a falling edge on `wake_pin_i` also clears the suspend bit, with the same timing as R6.
- R8: The trim register holds a 7-bit code in bits [6:0]. Bit 7 always reads 0, and the value written to bit 7 is discarded. The code is driven on `trim_o`.
- R9: A write to the trim register is ignored while control bit 3 (oscillator enable) is 1.
- R10: Edges on `wake_pin_i` while the block is not suspended change neither the registers nor the pulse spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 = control, 1 = trim |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| wake_pin_i | input | 1 | Asynchronous wake pin |
| clk_en_o | output | 1 | System clock-enable pulse |
| osc_en_o | output | 1 | Oscillator-enable bit to the analog oscillator |
| trim_o | output | 7 | Calibration code to the analog oscillator |

## Verification
A pulse appears one cycle after the dividers reach their terminal count. A suspend write silences `clk_en_o` from the very next cycle. A wake edge clears the suspend bit on the third rising clock edge after the pin changes. With a ratio of 1 and the prescaler frozen one step past its wrap, the first pulse after a wake then arrives on the sixth falling edge. The bench drives its inputs and samples the outputs on falling clock edges. It reads registers 1 ns after setting the address, and it measures every period from pulse to pulse. It expects each result only in the cycle counted above.

// File: rtl/oscdiv_pkg.sv
package oscdiv_pkg;
    localparam int DATA_W   = 8;
    localparam int TRIM_W   = 7;
    localparam int PRE_DIV  = 4;
    localparam int POST_MAX = 8;
    localparam int POST_W   = $clog2(POST_MAX);

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_TRIM = 1'b1;

    typedef enum logic [1:0] {
        DIV_1 = 2'd0,
        DIV_2 = 2'd1,
        DIV_4 = 2'd2,
        DIV_8 = 2'd3
    } div_sel_t;

    // Bit 3 osc enable, bit 2 suspend, bits 1:0 divide select
    typedef struct packed {
        logic     osc_en;
        logic     suspend;
        div_sel_t div;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [POST_W:0] ratio_of(div_sel_t d);
        return (POST_W+1)'(1) << d;
    endfunction
endpackage

// File: rtl/oscdiv_wake_sync.sv
module oscdiv_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/oscdiv_divider.sv
module oscdiv_divider
    import oscdiv_pkg::*;
#(
    parameter int PRE_DIV_P = oscdiv_pkg::PRE_DIV,
    localparam int PRE_W    = $clog2(PRE_DIV_P)
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     run_i,
    input  div_sel_t div_i,
    output logic     tick_o
);
    logic [PRE_W-1:0]  pre_cnt;
    logic [POST_W-1:0] post_cnt;
    div_sel_t          sel_q;
    logic              tick_q;
    logic              pre_tick, post_last, terminal;

    assign pre_tick  = (pre_cnt == PRE_W'(PRE_DIV_P - 1));
    assign post_last = ({1'b0, post_cnt} == (ratio_of(sel_q) - (POST_W+1)'(1)));
    assign terminal  = pre_tick & post_last;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pre_cnt  <= '0;
            post_cnt <= '0;
            sel_q    <= DIV_8;
            tick_q   <= 1'b0;
        end else begin
            tick_q <= run_i & terminal;
            if (run_i) begin
                pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
                if (pre_tick)
                    post_cnt <= post_last ? '0 : post_cnt + 1'b1;
                if (terminal)
                    sel_q <= div_i;
            end
        end
    end

    assign tick_o = tick_q;

    AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_q |=> !tick_q); // R2
    AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !terminal |=> $stable(sel_q)); // R4
    AST_COUNT_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> ($stable(pre_cnt) && $stable(post_cnt))); // R5
endmodule

// File: rtl/oscdiv_regs.sv
module oscdiv_regs
    import oscdiv_pkg::*;
#(
    parameter logic [TRIM_W-1:0] TRIM_RST = 7'h40
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wake_edge_i,
    output ctrl_t             ctrl_o,
    output logic [TRIM_W-1:0] trim_o,
    output logic [DATA_W-1:0] rdata_o
);
    ctrl_t             ctrl_q;
    logic [TRIM_W-1:0] trim_q;
    logic              wr_ctrl, wr_trim;

    assign wr_ctrl = wr_en_i & (addr_i == ADDR_CTRL);
    assign wr_trim = wr_en_i & (addr_i == ADDR_TRIM) & ~ctrl_q.osc_en;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q <= '{osc_en: 1'b1, suspend: 1'b0, div: DIV_8};
            trim_q <= TRIM_RST;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
            else if (wake_edge_i)
                ctrl_q.suspend <= 1'b0;
            if (wr_trim)
                trim_q <= wdata_i[TRIM_W-1:0];
        end
    end

    always_comb begin
        if (addr_i == ADDR_CTRL)
            rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        else
            rdata_o = {{(DATA_W-TRIM_W){1'b0}}, trim_q};
    end

    assign ctrl_o = ctrl_q;
    assign trim_o = trim_q;

    AST_SUSP_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_q.suspend && !wake_edge_i && !wr_ctrl) |=> ctrl_q.suspend); // R5
    AST_WAKE_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_q.suspend && wake_edge_i && !wr_ctrl) |=> !ctrl_q.suspend); // R6
    AST_TRIM_LOCK: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl_q.osc_en |=> $stable(trim_q)); // R9
endmodule

// File: rtl/osc_clk_div.sv
module osc_clk_div
    import oscdiv_pkg::*;
#(
    parameter logic [TRIM_W-1:0] TRIM_RST = 7'h40,
    parameter int SYNC_STAGES = 2,
    parameter int PRE_DIV_P   = oscdiv_pkg::PRE_DIV
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              wake_pin_i,
    output logic              clk_en_o,
    output logic              osc_en_o,
    output logic [TRIM_W-1:0] trim_o
);
    ctrl_t ctrl;
    logic  wake_edge;
    logic  tick;

    oscdiv_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .pin_i (wake_pin_i),
        .edge_o(wake_edge)
    );

    oscdiv_regs #(.TRIM_RST(TRIM_RST)) u_regs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .wake_edge_i(wake_edge),
        .ctrl_o     (ctrl),
        .trim_o     (trim_o),
        .rdata_o    (rdata_o)
    );

    oscdiv_divider #(.PRE_DIV_P(PRE_DIV_P)) u_div (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .run_i (~ctrl.suspend),
        .div_i (ctrl.div),
        .tick_o(tick)
    );

    // The tick register may already be set at the suspend write edge; mask it
    assign clk_en_o = tick & ~ctrl.suspend;
    assign osc_en_o = ctrl.osc_en;

    AST_RESUME_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(ctrl.suspend) |-> !tick); // R5
endmodule

// File: tb/osc_clk_div_tb_top.sv
module osc_clk_div_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic       addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       wake;
    logic       clk_en;
    logic       osc_en;
    logic [6:0] trim;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    osc_clk_div #(.TRIM_RST(7'h40)) dut_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .wake_pin_i(wake),
        .clk_en_o(clk_en), .osc_en_o(osc_en), .trim_o(trim)
    );

    localparam int NVEC = 4;
    localparam int VSEL [NVEC] = '{1, 3, 2, 0};
    localparam int VPER [NVEC] = '{8, 32, 16, 4};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!clk_en && n < 200);
    endtask

    task automatic count_quiet(input int cycles, output int hits);
        hits = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (clk_en) hits++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int n, hits, prev_per;
        rst = 1'b1; wr_en = 1'b0; addr = 1'b0; wdata = '0; wake = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 clk_en in reset", int'(clk_en), 0);
        rst = 1'b0;
        rd(1'b0, d); chk("R1 ctrl reset", int'(d), 8'h0B);
        rd(1'b1, d); chk("R1 trim reset", int'(d), 8'h40);
        chk("R1 osc_en reset", int'(osc_en), 1);

        // R3 reset ratio
        wait_pulse(n);
        wait_pulse(n); chk("R3 reset period", n, 32);
        @(negedge clk); chk("R2 pulse width", int'(clk_en), 0);

        // R3/R4 table walk
        prev_per = 32;
        for (int i = 0; i < NVEC; i++) begin
            wait_pulse(n);
            wr(1'b0, 8'h08 | 8'(VSEL[i]));
            wait_pulse(n); chk("R4 old period kept", n + 1, prev_per);
            wait_pulse(n); chk("R3 new period", n, VPER[i]);
            prev_per = VPER[i];
        end

        // R10 wake edges while running
        wake = 1'b1;
        repeat (6) @(negedge clk);
        rd(1'b0, d); chk("R10 ctrl after stray edge", int'(d), 8'h08);
        wait_pulse(n);
        wait_pulse(n); chk("R10 period after stray edge", n, 4);
        wake = 1'b0;
        repeat (6) @(negedge clk);

        // R5/R6 suspend and rising wake
        wait_pulse(n);
        wr(1'b0, 8'h0C);
        chk("R5 no pulse after write", int'(clk_en), 0);
        count_quiet(100, hits); chk("R5 quiet while suspended", hits, 0);
        rd(1'b0, d); chk("R5 suspend reads set", int'(d), 8'h0C);
        wake = 1'b1;
        wait_pulse(n); chk("R6 first pulse after rising wake (frozen count)", n, 6);
        rd(1'b0, d); chk("R6 suspend cleared", int'(d), 8'h08);
        wait_pulse(n); chk("R6 period after wake", n, 4);

        // R7 falling wake
        wait_pulse(n);
        wr(1'b0, 8'h0C);
        count_quiet(40, hits); chk("R5 quiet second suspend", hits, 0);
        wake = 1'b0;
        wait_pulse(n); chk("R7 first pulse after falling wake", n, 6);
        rd(1'b0, d); chk("R7 suspend cleared", int'(d), 8'h08);

        // R8/R9 trim
        @(negedge clk);
        wr(1'b1, 8'h15);
        rd(1'b1, d); chk("R9 trim write ignored", int'(d), 8'h40);
        chk("R9 trim_o unchanged", int'(trim), 8'h40);
        @(negedge clk);
        wr(1'b0, 8'h00);
        chk("R8 osc_en cleared", int'(osc_en), 0);
        wr(1'b1, 8'hD5);
        rd(1'b1, d); chk("R8 trim bit7 reads 0", int'(d), 8'h55);
        chk("R8 trim_o", int'(trim), 8'h55);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule